// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master for a small processor. It has three byte registers on a simple register bus: control, status and data. Software sets the clock mode, the bit order and the serial clock rate in the control register. A write to the data register then starts an 8-bit full-duplex exchange on `sclk`, `mosi` and `miso`. When the eighth bit has been exchanged, the byte captured from `miso` appears in the data register, the completion flag rises, and an interrupt request follows if interrupts are enabled.

A write to the data register while a byte is still moving does not start a new transfer. It is refused and recorded in a collision flag. Only the double-speed bit of the status register is writable. The two flags are cleared by the next accepted data write, and the completion flag is also cleared by an interrupt acknowledge pulse.

Top module: `spi_master_regs`

## Requirements
- R1: Register addresses are control = 0, status = 1 and data = 2, and reads are combinational. After reset every register reads 0x00, and `sclk`, `mosi` and `irq` are low.
- R2: The serial clock divider is 4, or 2 when status bit 0 (double speed) is set. It is multiplied by 1, 4, 16 or 32 for control bits [1:0] = 00, 01, 10 or 11. A transfer takes exactly 8 × divider clocks, from the clock edge that accepts the write to the clock edge that sets the completion flag.
- R3: A data write while control bit 6 (enable) is 0 is ignored: `sclk` does not move, and the status and data registers do not change.
- R4: A data write during a transfer sets status bit 6 (collision). It neither restarts nor alters the running transfer: the duration, the `mosi` bits and the received byte stay the same.
- R5: An accepted data write clears status bit 7 (complete) and status bit 6 (collision).
- R6: At the end of a transfer the received byte is loaded into the data register and status bit 7 is set.
- R7: `irq` is high exactly while control bit 7 (interrupt enable) and status bit 7 are both set. A one-cycle `irq_ack` pulse clears status bit 7.
- R8: `sclk` idles at control bit 3 (polarity) and makes 16 edges per transfer. With control bit 2 (phase) = 0, data is sampled on the odd edges (1st, 3rd, …) and shifted on the even edges. With phase = 1, these roles swap.
- R9: With control bit 5 = 0 the MSB is sent and received first. With control bit 5 = 1 the LSB is sent and received first.
- R10: The first output bit is on `mosi` in the cycle right after the accepting edge, before any `sclk` edge.
- R11: Status reads as {complete, collision, 00000, double-speed}, and writes to status change only bit 0. Reading the data register has no side effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong half-period counter or a wrong edge counter shows up on the first transfer. The completion interrupt then arrives one or more bit periods away from 8 × divider clocks, or `sclk` stops on the wrong idle level. A wrong sample or shift phase shows up in the byte read back from the data register and in the `mosi` sequence seen by a model slave, within that same transfer. Flag faults show up in the status read taken right after an accepted or refused write.

// File: rtl/spi_master_regs.sv
module spi_master_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       irq_ack,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam int HW = 7;
  localparam int EDGES = 16;

  logic [7:0]    ctrl, rxd, tx, rx;
  logic          spif, wcol, dbl, busy, tgl;
  logic          cpol_l, cpha_l, dord_l;
  logic [HW-1:0] half_l, hcnt, half_sel;
  logic [3:0]    kc;
  logic [2:0]    sh;

  wire wr      = bus_sel & bus_we;
  wire wr_ctrl = wr && bus_addr == ADDR_CTRL;
  wire wr_stat = wr && bus_addr == ADDR_STAT;
  wire wr_data = wr && bus_addr == ADDR_DATA;
  wire start   = wr_data && ctrl[6] && !busy;
  wire coll    = wr_data && ctrl[6] && busy;

  always_comb
    case (ctrl[1:0])
      2'b00:   sh = 3'd0;
      2'b01:   sh = 3'd2;
      2'b10:   sh = 3'd4;
      default: sh = 3'd5;
    endcase

  assign half_sel = (dbl ? 7'd1 : 7'd2) << sh;

  wire       tick   = busy && hcnt == '0;
  wire       last   = tick && kc == 4'(EDGES - 1);
  wire       smp    = tick && (kc[0] == cpha_l);
  wire       shf    = tick && (kc[0] != cpha_l) && kc != 4'd0;
  wire [7:0] rx_nxt = dord_l ? {miso, rx[7:1]} : {rx[6:0], miso};

  assign sclk = (busy ? cpol_l : ctrl[3]) ^ tgl;
  assign mosi = dord_l ? tx[0] : tx[7];
  assign irq  = ctrl[7] & spif;

  always_comb
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl;
      ADDR_STAT: bus_rdata = {spif, wcol, 5'b0, dbl};
      ADDR_DATA: bus_rdata = rxd;
      default:   bus_rdata = 8'h00;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; rxd <= '0; tx <= '0; rx <= '0;
      spif <= 1'b0; wcol <= 1'b0; dbl <= 1'b0; busy <= 1'b0; tgl <= 1'b0;
      cpol_l <= 1'b0; cpha_l <= 1'b0; dord_l <= 1'b0;
      half_l <= '0; hcnt <= '0; kc <= '0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata;
      if (wr_stat) dbl <= bus_wdata[0];
      if (irq_ack) spif <= 1'b0;
      if (coll) wcol <= 1'b1;
      if (start) begin
        wcol   <= 1'b0;
        spif   <= 1'b0;
        busy   <= 1'b1;
        tx     <= bus_wdata;
        half_l <= half_sel;
        hcnt   <= half_sel - 7'd1;
        kc     <= '0;
        tgl    <= 1'b0;
        cpol_l <= ctrl[3];
        cpha_l <= ctrl[2];
        dord_l <= ctrl[5];
      end
      if (busy && !tick) hcnt <= hcnt - 7'd1;
      if (tick) begin
        hcnt <= half_l - 7'd1;
        tgl  <= ~tgl;
        kc   <= kc + 4'd1;
        if (smp) rx <= rx_nxt;
        if (shf) tx <= dord_l ? {1'b0, tx[7:1]} : {tx[6:0], 1'b0};
      end
      if (last) begin
        busy <= 1'b0;
        spif <= 1'b1;
        rxd  <= smp ? rx_nxt : rx;
      end
    end
  end

  assert_disabled_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ctrl[6] && !busy) |=> !busy);
  assert_collision_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> wcol);
  assert_collision_keeps_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && !tick) |=> (busy && kc == $past(kc)));
  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !spif && !wcol));
  assert_flag_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> ($past(busy) && !busy));
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !last) |=> !spif);
  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == ctrl[3]);
endmodule

// File: tb/spi_master_regs_test.sv
module spi_master_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0, irq_ack = 1'b0, miso = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, sclk, mosi;
  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  spi_master_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .irq_ack(irq_ack), .sclk(sclk), .mosi(mosi), .miso(miso));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic slave_bit(input logic [7:0] s, input logic lsb, input int i);
    if (i > 7) return 1'b0;
    return lsb ? s[i] : s[7-i];
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic run_xfer(input logic cpol, input logic cpha, input logic lsb,
                          input logic [1:0] rate, input logic dbl,
                          input logic [7:0] m, input logic [7:0] s,
                          input bit coll, input bit do_ack);
    int div, c, edges, ptr;
    logic [7:0] seq, rd;
    logic prev;
    bit done;
    div = (dbl ? 2 : 4) * (rate == 0 ? 1 : rate == 1 ? 4 : rate == 2 ? 16 : 32);
    bus_write(2'd0, {1'b1, 1'b1, lsb, 1'b1, cpol, cpha, rate});
    bus_write(2'd1, {7'b0, dbl});
    ptr = 0;
    miso = slave_bit(s, lsb, 0);
    chk("R8 idle sclk", sclk, cpol);
    bus_write(2'd2, m);
    bus_read(2'd1, rd);
    chk("R5 flags cleared by accepted write", rd, {7'b0, dbl});
    chk("R10 first bit on mosi", mosi, lsb ? m[0] : m[7]);
    c = 0; edges = 0; seq = 0; prev = sclk; done = 0;
    while (!done && c < 5000) begin
      @(negedge clk);
      c++;
      if (coll && c == 10) begin
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'hFF;
      end
      if (coll && c == 11) begin
        bus_sel = 1'b0; bus_we = 1'b0;
      end
      if (sclk != prev) begin
        prev = sclk;
        if ((edges % 2) == int'(cpha)) seq = {seq[6:0], mosi};
        else if (edges != 0) begin
          ptr++;
          miso = slave_bit(s, lsb, ptr);
        end
        edges++;
      end
      if (irq) done = 1;
    end
    chk("R2 transfer length", c, 8 * div);
    chk("R8 sclk edge count", edges, 16);
    chk("R8 sclk back to idle", sclk, cpol);
    chk("R9 mosi bit order", seq, lsb ? rev8(m) : m);
    bus_read(2'd2, rd);
    chk("R6 received byte", rd, s);
    bus_read(2'd1, rd);
    chk(coll ? "R4 collision flag" : "R11 status after data read", rd,
        {1'b1, coll, 5'b0, dbl});
    chk("R7 irq raised", irq, 1);
    if (do_ack) begin
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      chk("R7 irq after ack", irq, 0);
      bus_read(2'd1, rd);
      chk("R7 flag cleared by ack", rd, {7'b0, dbl});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int idx, moves;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_read(2'd0, rd); chk("R1 control reset", rd, 0);
    bus_read(2'd1, rd); chk("R1 status reset", rd, 0);
    bus_read(2'd2, rd); chk("R1 data reset", rd, 0);
    chk("R1 sclk reset", sclk, 0);
    chk("R1 mosi reset", mosi, 0);
    chk("R1 irq reset", irq, 0);

    bus_write(2'd1, 8'hFE);
    bus_read(2'd1, rd); chk("R11 status write masks flags", rd, 8'h00);
    bus_write(2'd1, 8'hC1);
    bus_read(2'd1, rd); chk("R11 status write bit0 only", rd, 8'h01);
    bus_write(2'd1, 8'h00);

    bus_write(2'd0, 8'h98);
    bus_write(2'd2, 8'hA5);
    moves = 0; prev = sclk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk != prev) moves++;
      prev = sclk;
    end
    chk("R3 sclk still when disabled", moves, 0);
    bus_read(2'd1, rd); chk("R3 status untouched", rd, 0);
    bus_read(2'd2, rd); chk("R3 data untouched", rd, 0);
    chk("R3 no irq", irq, 0);

    idx = 0;
    for (int cp = 0; cp < 2; cp++)
      for (int ph = 0; ph < 2; ph++)
        for (int lo = 0; lo < 2; lo++)
          for (int rt = 0; rt < 4; rt++)
            for (int d2 = 0; d2 < 2; d2++) begin
              run_xfer(cp[0], ph[0], lo[0], rt[1:0], d2[0],
                       8'(idx * 37 + 11), 8'(idx * 91 + 200), 1'b0, 1'b1);
              idx++;
            end

    run_xfer(1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 8'h3C, 8'hC3, 1'b1, 1'b0);
    run_xfer(1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 8'h81, 8'h7E, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule